// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block is the execution slice of an 8-bit accumulator processor that handles the bit-test instructions and the two read-modify-write instructions that set or clear memory bits under an accumulator mask. The surrounding core supplies an opcode, the accumulator, the effective address that it has already formed, and an immediate byte for the immediate form. The unit then talks to a synchronous memory port on its own and updates its zero, negative and overflow flags.

A small sequencer drives the memory port. It runs a read cycle and then a modify cycle. The read-modify-write opcodes add a write cycle to the same address. A `done` strobe marks the end of each instruction. An opcode outside the supported set raises a one-cycle `illegal` pulse and touches nothing. A parameter removes the read-modify-write variant, and those opcodes are then treated as illegal.

Top module: `btm_unit`

## Requirements
- R1: While reset is held and just after it is released, the flags read 0, and `mem_rd`, `mem_wr`, `busy`, `done` and `illegal` are all low.
- R2: The memory bit-test opcodes 0x24, 0x2C, 0x34 and 0x3C set Z when (operand AND accumulator) is zero, copy operand bit 7 into N and operand bit 6 into V, and never assert `mem_wr`.
- R3: Immediate opcode 0x89 sets Z from (`imm_data` AND accumulator), leaves N and V unchanged, performs no memory access, and pulses `done` in the cycle after it is accepted.
- R4: Opcodes 0x04 (zero page) and 0x0C (absolute) set Z from (operand AND accumulator), leave N and V unchanged, and write (operand OR accumulator) back to the address that was read.
- R5: Opcodes 0x14 (zero page) and 0x1C (absolute) set Z from (operand AND accumulator), leave N and V unchanged, and write (operand AND NOT accumulator) back to the address that was read.
- R6: When start is accepted on clock edge E0, `mem_rd` is high from E0 to E1 and data returns after E1. A bit test pulses `done` from E2 to E3. A read-modify-write holds `mem_wr` high from E2 to E3 only and pulses `done` from E3 to E4.
- R7: `mem_rd` and `mem_wr` are never high together. `mem_addr` holds the effective address captured at acceptance for the whole instruction, even if `ea` changes.
- R8: Any other opcode pulses `illegal` for the one cycle after acceptance. It leaves the flags unchanged, makes no memory access and gives no `done`.
- R9: `start` is ignored while `busy` is high. The running instruction completes with its captured operands.
- R10: With the read-modify-write variant disabled (`EN_RMW` = 0), opcodes 0x04, 0x0C, 0x14 and 0x1C are handled as illegal under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Instruction opcode |
| acc | input | DW | Accumulator value |
| imm_data | input | DW | Immediate operand for 0x89 |
| ea | input | AW | Effective address for memory forms |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read request, data valid next cycle |
| mem_rdata | input | DW | Memory read data |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction complete strobe |
| illegal | output | 1 | Unsupported opcode strobe |

## Verification
The bench builds two copies of the unit. Both use DW = 8 and AW = 16, so the flag bits sit at positions 7 and 6 and the upper address byte can differ between the captured address and a changed `ea`. The main copy has `EN_RMW` = 1. It runs every supported opcode, immediate and memory alike, as well as illegal ones, with masks that cover both zero and non-zero AND results. The second copy has `EN_RMW` = 0. It shows that the set and clear opcodes fall to the illegal path while the bit tests still run.

// File: rtl/btm_pkg.sv
package btm_pkg;

   // Instruction class resolved from the opcode
   typedef enum logic [2:0] {
      BK_NONE,
      BK_TEST_IMM,
      BK_TEST_MEM,
      BK_SET,
      BK_CLR
   } btm_kind_e;

   // Sequencer phases
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_MOD,
      ST_WRITE
   } btm_state_e;

   localparam logic [7:0] OPC_TEST_ZP   = 8'h24;
   localparam logic [7:0] OPC_TEST_ABS  = 8'h2C;
   localparam logic [7:0] OPC_TEST_ZPX  = 8'h34;
   localparam logic [7:0] OPC_TEST_ABSX = 8'h3C;
   localparam logic [7:0] OPC_TEST_IMM  = 8'h89;
   localparam logic [7:0] OPC_SET_ZP    = 8'h04;
   localparam logic [7:0] OPC_SET_ABS   = 8'h0C;
   localparam logic [7:0] OPC_CLR_ZP    = 8'h14;
   localparam logic [7:0] OPC_CLR_ABS   = 8'h1C;

endpackage

// File: rtl/btm_decode.sv
module btm_decode
   import btm_pkg::*;
#(
   parameter bit EN_RMW = 1'b1
) (
   input  logic [7:0] opcode,
   output btm_kind_e  kind
);

   btm_kind_e base_kind;

   always_comb begin
      case (opcode)
         OPC_TEST_ZP, OPC_TEST_ABS,
         OPC_TEST_ZPX, OPC_TEST_ABSX: base_kind = BK_TEST_MEM;
         OPC_TEST_IMM:                base_kind = BK_TEST_IMM;
         OPC_SET_ZP, OPC_SET_ABS:     base_kind = BK_SET;
         OPC_CLR_ZP, OPC_CLR_ABS:     base_kind = BK_CLR;
         default:                     base_kind = BK_NONE;
      endcase
   end

   generate
      if (EN_RMW) begin : g_full
         assign kind = base_kind;
      end else begin : g_read_only
         // set/clear opcodes fall through to the illegal path
         assign kind = (base_kind == BK_SET || base_kind == BK_CLR) ? BK_NONE : base_kind;
      end
   endgenerate

endmodule

// File: rtl/btm_alu.sv
module btm_alu
   import btm_pkg::*;
#(
   parameter int DW = 8
) (
   input  btm_kind_e         kind,
   input  logic [DW-1:0]     acc,
   input  logic [DW-1:0]     opnd,
   output logic              res_z,
   output logic              res_n,
   output logic              res_v,
   output logic [DW-1:0]     res_data
);

   localparam int N_POS = DW - 1;
   localparam int V_POS = DW - 2;

   generate
      if (DW < 2) begin : g_bad_width
         $error("btm_alu: DW must be at least 2");
      end
   endgenerate

   always_comb begin
      res_z = ~|(opnd & acc);
      res_n = opnd[N_POS];
      res_v = opnd[V_POS];
      if (kind == BK_SET) res_data = opnd | acc;
      else                res_data = opnd & ~acc;
   end

endmodule

// File: rtl/btm_seq.sv
module btm_seq
   import btm_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  btm_kind_e      kind_in,
   input  logic [AW-1:0]  ea,
   output btm_kind_e      kind_q,
   output logic [AW-1:0]  addr_q,
   output logic           accept,
   output logic           idle,
   output logic           busy,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           imm_we,
   output logic           mod_we,
   output logic           done,
   output logic           illegal
);

   generate
      if (AW < 1) begin : g_bad_addr
         $error("btm_seq: AW must be at least 1");
      end
   endgenerate

   btm_state_e state;

   assign idle   = (state == ST_IDLE);
   assign busy   = !idle;
   assign accept = idle && start;
   assign mem_rd = (state == ST_READ);
   assign mem_wr = (state == ST_WRITE);
   assign mod_we = (state == ST_MOD);
   assign imm_we = accept && (kind_in == BK_TEST_IMM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind_q  <= BK_NONE;
         addr_q  <= '0;
         done    <= 1'b0;
         illegal <= 1'b0;
      end else begin
         done    <= 1'b0;
         illegal <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  kind_q <= kind_in;
                  addr_q <= ea;
                  if (kind_in == BK_NONE)          illegal <= 1'b1;
                  else if (kind_in == BK_TEST_IMM) done    <= 1'b1;
                  else                             state   <= ST_READ;
               end
            end
            ST_READ:  state <= ST_MOD;
            ST_MOD: begin
               if (kind_q == BK_TEST_MEM) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default:  state <= ST_IDLE;
         endcase
      end
   end

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));                                        // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(addr_q));                     // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                              // R6
   AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !busy && !done);                                  // R8

endmodule

// File: rtl/btm_unit.sv
module btm_unit
   import btm_pkg::*;
#(
   parameter int DW     = 8,
   parameter int AW     = 16,
   parameter bit EN_RMW = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [7:0]     opcode,
   input  logic [DW-1:0]  acc,
   input  logic [DW-1:0]  imm_data,
   input  logic [AW-1:0]  ea,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   input  logic [DW-1:0]  mem_rdata,
   output logic           mem_wr,
   output logic [DW-1:0]  mem_wdata,
   output logic           flag_z,
   output logic           flag_n,
   output logic           flag_v,
   output logic           busy,
   output logic           done,
   output logic           illegal
);

   btm_kind_e      dec_kind;
   btm_kind_e      kind_q;
   logic           accept, idle, imm_we, mod_we;
   logic [DW-1:0]  acc_q, wbuf;
   logic [DW-1:0]  alu_acc, alu_opnd, alu_data;
   logic           alu_z, alu_n, alu_v;

   btm_decode #(.EN_RMW(EN_RMW)) u_decode (
      .opcode (opcode),
      .kind   (dec_kind)
   );

   btm_seq #(.AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .kind_in (dec_kind),
      .ea      (ea),
      .kind_q  (kind_q),
      .addr_q  (mem_addr),
      .accept  (accept),
      .idle    (idle),
      .busy    (busy),
      .mem_rd  (mem_rd),
      .mem_wr  (mem_wr),
      .imm_we  (imm_we),
      .mod_we  (mod_we),
      .done    (done),
      .illegal (illegal)
   );

   // Immediate form computes on the accept cycle; memory forms on the modify cycle
   assign alu_acc  = idle ? acc      : acc_q;
   assign alu_opnd = idle ? imm_data : mem_rdata;

   btm_alu #(.DW(DW)) u_alu (
      .kind     (kind_q),
      .acc      (alu_acc),
      .opnd     (alu_opnd),
      .res_z    (alu_z),
      .res_n    (alu_n),
      .res_v    (alu_v),
      .res_data (alu_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         wbuf   <= '0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
         flag_v <= 1'b0;
      end else begin
         if (accept) acc_q <= acc;
         if (imm_we) flag_z <= alu_z;
         if (mod_we) begin
            flag_z <= alu_z;
            wbuf   <= alu_data;
            if (kind_q == BK_TEST_MEM) begin
               flag_n <= alu_n;
               flag_v <= alu_v;
            end
         end
      end
   end

   assign mem_wdata = wbuf;

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (kind_q == BK_SET || kind_q == BK_CLR));           // R2
   AST_IMM_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      imm_we |=> $stable({flag_n, flag_v}));                        // R3
   AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && kind_q == BK_SET |-> (mem_wdata & acc_q) == acc_q); // R4
   AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && kind_q == BK_CLR |-> (mem_wdata & acc_q) == '0);    // R5

endmodule

// File: tb/test_btm_unit.sv
`timescale 1ns/1ps
module test_btm_unit;

   localparam int DW = 8;
   localparam int AW = 16;

   typedef struct packed {
      logic [7:0]  opc;
      logic [7:0]  a;
      logic [7:0]  opnd;
      logic [15:0] addr;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h24, 8'h0F, 8'hC0, 16'h0010},
      '{8'h2C, 8'hFF, 8'h01, 16'h1211},
      '{8'h34, 8'h40, 8'h40, 16'h0012},
      '{8'h3C, 8'h00, 8'h80, 16'h3413},
      '{8'h89, 8'h01, 8'hFE, 16'h0000},
      '{8'h89, 8'h80, 8'h80, 16'h0000},
      '{8'h04, 8'h0F, 8'hF0, 16'h0020},
      '{8'h0C, 8'h81, 8'h01, 16'h5621},
      '{8'h14, 8'h0F, 8'hFF, 16'h0022},
      '{8'h1C, 8'h01, 8'h02, 16'h7823},
      '{8'h02, 8'hFF, 8'hFF, 16'h0030},
      '{8'hFF, 8'h00, 8'h00, 16'h0031}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          start = 1'b0, lite_start = 1'b0;
   logic [7:0]    opcode = 8'h00;
   logic [DW-1:0] acc = '0, imm_data = '0;
   logic [AW-1:0] ea = '0;
   logic [AW-1:0] mem_addr, lite_addr;
   logic          mem_rd, mem_wr, lite_rd, lite_wr;
   logic [DW-1:0] mem_rdata = '0, mem_wdata, lite_wdata;
   logic [DW-1:0] lite_rdata = '0;
   logic          flag_z, flag_n, flag_v, busy, done, illegal;
   logic          lite_z, lite_n, lite_v, lite_busy, lite_done, lite_ill;

   btm_unit #(.DW(DW), .AW(AW), .EN_RMW(1'b1)) i_btm_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
      .imm_data(imm_data), .ea(ea), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .busy(busy),
      .done(done), .illegal(illegal)
   );

   btm_unit #(.DW(DW), .AW(AW), .EN_RMW(1'b0)) i_btm_unit_lite (
      .clk(clk), .rst_n(rst_n), .start(lite_start), .opcode(opcode), .acc(acc),
      .imm_data(imm_data), .ea(ea), .mem_addr(lite_addr), .mem_rd(lite_rd),
      .mem_rdata(lite_rdata), .mem_wr(lite_wr), .mem_wdata(lite_wdata),
      .flag_z(lite_z), .flag_n(lite_n), .flag_v(lite_v), .busy(lite_busy),
      .done(lite_done), .illegal(lite_ill)
   );

   // Synchronous memory model with a preload port
   logic [7:0] mem [256];
   logic       pl_en = 1'b0;
   logic [7:0] pl_addr = 8'h00, pl_data = 8'h00;

   always @(posedge clk) begin
      if (pl_en) mem[pl_addr] <= pl_data;
      else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
   end

   // Monitor, sampled away from the active edge
   int rd_cnt = 0, wr_cnt = 0, dn_cnt = 0, il_cnt = 0;
   int lrd_cnt = 0, ldn_cnt = 0, lil_cnt = 0;
   logic [AW-1:0] last_waddr = '0;
   logic [DW-1:0] last_wdata = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         rd_cnt  += int'(mem_rd);
         wr_cnt  += int'(mem_wr);
         dn_cnt  += int'(done);
         il_cnt  += int'(illegal);
         lrd_cnt += int'(lite_rd) + int'(lite_wr);
         ldn_cnt += int'(lite_done);
         lil_cnt += int'(lite_ill);
         if (mem_wr) begin
            last_waddr = mem_addr;
            last_wdata = mem_wdata;
         end
      end
   end

   int n_tests = 0, n_fail = 0;
   int d_rd, d_wr, d_dn, d_il;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic preload(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #5;
      pl_en = 1'b1; pl_addr = a; pl_data = d;
      @(posedge clk); #5;
      pl_en = 1'b0;
   endtask

   task automatic do_op(input logic [7:0] o, input logic [7:0] a,
                        input logic [15:0] e, input logic [7:0] im);
      int b_rd, b_wr, b_dn, b_il;
      @(posedge clk); #5;
      b_rd = rd_cnt; b_wr = wr_cnt; b_dn = dn_cnt; b_il = il_cnt;
      opcode = o; acc = a; ea = e; imm_data = im; start = 1'b1;
      @(posedge clk); #5;
      start = 1'b0;
      repeat (5) @(posedge clk);
      #5;
      d_rd = rd_cnt - b_rd; d_wr = wr_cnt - b_wr;
      d_dn = dn_cnt - b_dn; d_il = il_cnt - b_il;
   endtask

   initial begin
      #(20.0 * 200000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL R6 watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic mz, mn, mv;
      // R1: state while reset is held
      repeat (3) @(posedge clk);
      #5;
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "rd/wr in reset", {mem_rd, mem_wr}, 0);
      chk("R1", "flags in reset", {flag_z, flag_n, flag_v}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "done/illegal after reset", {done, illegal}, 0);
      chk("R1", "flags after reset", {flag_z, flag_n, flag_v}, 0);
      mz = 1'b0; mn = 1'b0; mv = 1'b0;

      // Vector table walk, expected values from the requirements
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         bit is_tm, is_im, is_set, is_clr, legal;
         string rq;
         v      = VECS[i];
         is_tm  = (v.opc == 8'h24 || v.opc == 8'h2C || v.opc == 8'h34 || v.opc == 8'h3C);
         is_im  = (v.opc == 8'h89);
         is_set = (v.opc == 8'h04 || v.opc == 8'h0C);
         is_clr = (v.opc == 8'h14 || v.opc == 8'h1C);
         legal  = is_tm || is_im || is_set || is_clr;
         rq = is_tm ? "R2" : is_im ? "R3" : is_set ? "R4" : is_clr ? "R5" : "R8";
         if (is_tm || is_set || is_clr) preload(v.addr[7:0], v.opnd);
         do_op(v.opc, v.a, v.addr, v.opnd);
         if (legal) mz = ((v.opnd & v.a) == 8'h00);
         if (is_tm) begin mn = v.opnd[7]; mv = v.opnd[6]; end
         chk(rq, "Z", flag_z, mz);
         chk(rq, "N", flag_n, mn);
         chk(rq, "V", flag_v, mv);
         chk(rq, "read count", d_rd, (is_tm || is_set || is_clr) ? 1 : 0);
         chk(rq, "write count", d_wr, (is_set || is_clr) ? 1 : 0);
         chk(rq, "done count", d_dn, legal ? 1 : 0);
         chk(rq, "illegal count", d_il, legal ? 0 : 1);
         if (is_set) chk("R4", "write data", last_wdata, v.opnd | v.a);
         if (is_clr) chk("R5", "write data", last_wdata, v.opnd & ~v.a);
         if (is_set || is_clr) chk(rq, "write address", last_waddr, v.addr);
      end

      // R6/R7: cycle-by-cycle read-modify-write with ea moving mid-instruction
      preload(8'h40, 8'h0F);
      @(posedge clk); #5;
      opcode = 8'h0C; acc = 8'h30; ea = 16'h0140; start = 1'b1;
      @(posedge clk); #5;
      start = 1'b0; ea = 16'h0777; acc = 8'hFF;
      @(negedge clk);
      chk("R6", "read phase rd", {mem_rd, mem_wr, busy}, 3'b101);
      chk("R7", "read phase addr", mem_addr, 16'h0140);
      @(negedge clk);
      chk("R6", "modify phase idle port", {mem_rd, mem_wr, done}, 0);
      @(negedge clk);
      chk("R6", "write phase", {mem_rd, mem_wr, done}, 3'b010);
      chk("R7", "write addr held", mem_addr, 16'h0140);
      chk("R4", "write data uses captured acc", mem_wdata, 8'h3F);
      @(negedge clk);
      chk("R6", "rmw done strobe", {mem_wr, done, busy}, 3'b010);
      chk("R4", "Z set on zero AND", flag_z, 1);

      // R6: read-only timing
      preload(8'h41, 8'h81);
      @(posedge clk); #5;
      opcode = 8'h2C; acc = 8'h01; ea = 16'h0041; start = 1'b1;
      @(posedge clk); #5;
      start = 1'b0;
      @(negedge clk);
      chk("R6", "test read", mem_rd, 1);
      @(negedge clk);
      chk("R6", "test no early done", done, 0);
      @(negedge clk);
      chk("R6", "test done", {done, mem_wr}, 2'b10);
      chk("R2", "flags", {flag_z, flag_n, flag_v}, 3'b010);

      // R3: immediate done in the cycle after acceptance
      @(posedge clk); #5;
      opcode = 8'h89; acc = 8'h02; imm_data = 8'h02; start = 1'b1;
      @(posedge clk); #5;
      start = 1'b0;
      @(negedge clk);
      chk("R3", "imm done timing", {done, mem_rd, flag_z}, 3'b100);
      chk("R3", "imm N/V held", {flag_n, flag_v}, 2'b10);

      // R9: start held and opcode changed while busy
      preload(8'h50, 8'h00);
      @(posedge clk); #5;
      d_dn = dn_cnt; d_rd = rd_cnt;
      opcode = 8'h24; acc = 8'hFF; ea = 16'h0050; start = 1'b1;
      @(posedge clk); #5;
      opcode = 8'h89; imm_data = 8'hFF;
      @(posedge clk); #5;
      start = 1'b0;
      repeat (5) @(posedge clk);
      #5;
      chk("R9", "single done", dn_cnt - d_dn, 1);
      chk("R9", "single read", rd_cnt - d_rd, 1);
      chk("R9", "flags from first", {flag_z, flag_n, flag_v}, 3'b100);

      // R10: read-only build treats set/clear as illegal
      @(posedge clk); #5;
      d_il = lil_cnt; d_rd = lrd_cnt; d_dn = ldn_cnt;
      opcode = 8'h14; acc = 8'h0F; ea = 16'h0060; lite_start = 1'b1;
      @(posedge clk); #5;
      lite_start = 1'b0;
      repeat (5) @(posedge clk);
      #5;
      chk("R10", "illegal pulse", lil_cnt - d_il, 1);
      chk("R10", "no memory access", lrd_cnt - d_rd, 0);
      chk("R10", "no done", ldn_cnt - d_dn, 0);
      @(posedge clk); #5;
      d_dn = ldn_cnt;
      opcode = 8'h2C; lite_start = 1'b1;
      @(posedge clk); #5;
      lite_start = 1'b0;
      repeat (5) @(posedge clk);
      #5;
      chk("R10", "bit test still runs", ldn_cnt - d_dn, 1);
      chk("R10", "bit test Z", lite_z, 1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule